// File: doc/BRIEF.md
# Port-Width Sub-Word Address Counter

This block drives the four low address lines that tell an external memory which piece of the current data line the bus master expects on each data transfer. Memory ports may be 8, 16 or 32 bits wide. For a single datum (byte, halfword or word), the lines first show the target address. When the datum is wider than the port, the transfer is split into a mini-burst, and the address moves up by the port width on every acknowledge until the whole datum has been moved. For a four-word line read (quad read), the lines count from zero across the 16-byte line, in steps of the port width.

A transfer begins with a one-cycle start request that carries the target address, datum size, port width and quad flag. The memory side then acknowledges each datum. The block shows a last-transfer flag while the final datum is pending. A done pulse marks the acknowledge that completes the transfer, and the block then returns to idle. Steering data onto byte lanes is handled elsewhere.

Top module: `subword_addr_ctr`

## Requirements
- R1: After reset, and whenever no transfer is in progress, the address lines, the last flag and the done output are all zero.
- R2: Port width is encoded 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit. Datum size is encoded 0 = byte, 1 = halfword, 2 or 3 = word. For a single transfer, the first address appears in the cycle after the start is accepted. It equals the target address with the address bits below the port width cleared.
- R3: A single transfer takes one datum per acknowledge. The number of data is the datum byte count divided by the port byte count, and never fewer than one.
- R4: Every acknowledge that does not complete the transfer raises the address by the port width in bytes (1, 2 or 4), counted modulo 16. The new address is visible in the next cycle.
- R5: A quad read starts at address 0000 and takes 16, 8 or 4 data for an 8-, 16- or 32-bit port.
- R6: While no acknowledge is given, the address lines hold their value.
- R7: Address bits that carry no meaning for the port width are zero: bits 1:0 for a 32-bit port and bit 0 for a 16-bit port.
- R8: The last flag is high exactly while the final datum of a transfer is pending.
- R9: The done output is high only in the cycle of the final acknowledge. In the next cycle the block is idle.
- R10: A start request made while a transfer is in progress is ignored. The address sequence of the running transfer is unchanged.
- R11: In a quad read the datum size input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| tgt_addr_i | input | 4 | Low target address, sampled at start |
| dsize_i | input | 2 | Datum size code, sampled at start |
| pwidth_i | input | 2 | Port width code, sampled at start |
| quad_i | input | 1 | Quad read select, sampled at start |
| ack_i | input | 1 | Per-datum acknowledge from memory |
| addr_o | output | 4 | Low address lines |
| last_o | output | 1 | Final datum pending |
| done_o | output | 1 | Transfer completes this cycle |

## Verification
The assertions check the following on every cycle:
- the idle lines are zero;
- the address holds without an acknowledge;
- each non-final acknowledge adds exactly the latched step;
- the unused low bits stay clear for the port width;
- a quad read opens at zero;
- done coincides with last and is followed by idle;
- a start during a transfer leaves the state untouched.

Only the bench scenarios can show that the whole sequence is correct for each combination of size and width. That includes the exact first address of a single transfer, the total number of data, and the fact that quad reads ignore the datum size. The bench compares each of these with a list of addresses it builds itself.

// File: rtl/swa_pkg.sv
package swa_pkg;

  // Port width codes (3 aliases the 32-bit port)
  localparam logic [1:0] PW_8  = 2'd0;
  localparam logic [1:0] PW_16 = 2'd1;

  // Datum size codes (3 aliases the word)
  localparam logic [1:0] DS_BYTE = 2'd0;
  localparam logic [1:0] DS_HALF = 2'd1;

  // Bytes carried per datum on a port of the given width code
  function automatic int unsigned port_bytes(input logic [1:0] pw);
    case (pw)
      PW_8:    return 1;
      PW_16:   return 2;
      default: return 4;
    endcase
  endfunction

  // Bytes in a datum of the given size code
  function automatic int unsigned datum_bytes(input logic [1:0] ds);
    case (ds)
      DS_BYTE: return 1;
      DS_HALF: return 2;
      default: return 4;
    endcase
  endfunction

  // Data moved for one single transfer: size over width, at least one
  function automatic int unsigned single_count(input int unsigned db,
                                               input int unsigned pb);
    if (db > pb) return db / pb;
    return 1;
  endfunction

  // Data moved for a quad read across a line of line_b bytes
  function automatic int unsigned quad_count(input int unsigned line_b,
                                             input int unsigned pb);
    return line_b / pb;
  endfunction

  // Whether address bit b still selects bytes on a port of pb bytes
  function automatic bit bit_meaningful(input int unsigned b,
                                        input int unsigned pb);
    return (32'd1 << b) >= pb;
  endfunction

endpackage

// File: rtl/swa_plan.sv
// Works out the first address, the number of data and the step for a
// transfer from the request inputs. Purely combinational.
module swa_plan #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [1:0]        dsize,
  input  logic [1:0]        pwidth,
  input  logic              quad,
  output logic [ADDR_W-1:0] init_addr,
  output logic [CNT_W-1:0]  init_cnt,
  output logic [ADDR_W-1:0] step
);
  import swa_pkg::*;

  localparam int unsigned LINE_BYTES = 1 << ADDR_W;

  logic [ADDR_W-1:0] keep_mask;
  logic [ADDR_W-1:0] aligned_tgt;
  int unsigned       pb;
  int unsigned       db;

  always_comb begin
    pb = port_bytes(pwidth);
    db = datum_bytes(dsize);
  end

  // Keep only the address bits that select bytes at this port width
  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    assign keep_mask[b] = bit_meaningful(b, pb);
  end

  assign aligned_tgt = tgt_addr & keep_mask;

  always_comb begin
    step = ADDR_W'(pb);
    if (quad) begin
      init_addr = '0;
      init_cnt  = CNT_W'(quad_count(LINE_BYTES, pb));
    end else begin
      init_addr = aligned_tgt;
      init_cnt  = CNT_W'(single_count(db, pb));
    end
  end

endmodule

// File: rtl/swa_seq.sv
// Holds the transfer state: busy flag, current address, data remaining
// and the latched step.
module swa_seq #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              advance,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [CNT_W-1:0]  init_cnt,
  input  logic [ADDR_W-1:0] init_step,
  output logic              active,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  remaining,
  output logic [ADDR_W-1:0] step
);

  logic final_beat;

  assign final_beat = advance && (remaining == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cur_addr  <= '0;
      remaining <= '0;
      step      <= '0;
    end else if (accept) begin
      active    <= 1'b1;
      cur_addr  <= init_addr;
      remaining <= init_cnt;
      step      <= init_step;
    end else if (final_beat) begin
      active    <= 1'b0;
      cur_addr  <= '0;
      remaining <= '0;
    end else if (advance) begin
      cur_addr  <= cur_addr + step;
      remaining <= remaining - CNT_W'(1);
    end
  end

endmodule

// File: rtl/swa_out.sv
// Shapes the outputs from the transfer state.
module swa_out #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              active,
  input  logic              advance,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  remaining,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              done_o
);

  assign addr_o = active ? cur_addr : '0;
  assign last_o = active && (remaining == CNT_W'(1));
  assign done_o = advance && last_o;

endmodule

// File: rtl/subword_addr_ctr.sv
module subword_addr_ctr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic [1:0]        dsize_i,
  input  logic [1:0]        pwidth_i,
  input  logic              quad_i,
  input  logic              ack_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              done_o
);

  localparam int CNT_W = ADDR_W + 1;

  // Named internal events, visible to the bound checker
  logic              accept_w;
  logic              advance_w;
  logic              active_w;
  logic [ADDR_W-1:0] cur_addr_w;
  logic [CNT_W-1:0]  rem_w;
  logic [ADDR_W-1:0] step_w;
  logic [ADDR_W-1:0] init_addr_w;
  logic [CNT_W-1:0]  init_cnt_w;
  logic [ADDR_W-1:0] init_step_w;

  assign accept_w  = start_i && !active_w;
  assign advance_w = ack_i && active_w;

  swa_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_plan (
    .tgt_addr  (tgt_addr_i),
    .dsize     (dsize_i),
    .pwidth    (pwidth_i),
    .quad      (quad_i),
    .init_addr (init_addr_w),
    .init_cnt  (init_cnt_w),
    .step      (init_step_w)
  );

  swa_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept_w),
    .advance   (advance_w),
    .init_addr (init_addr_w),
    .init_cnt  (init_cnt_w),
    .init_step (init_step_w),
    .active    (active_w),
    .cur_addr  (cur_addr_w),
    .remaining (rem_w),
    .step      (step_w)
  );

  swa_out #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_out (
    .active    (active_w),
    .advance   (advance_w),
    .cur_addr  (cur_addr_w),
    .remaining (rem_w),
    .addr_o    (addr_o),
    .last_o    (last_o),
    .done_o    (done_o)
  );

endmodule

// File: rtl/swa_chk.sv
module swa_chk #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              quad_i,
  input logic              ack_i,
  input logic              accept,
  input logic              active,
  input logic [CNT_W-1:0]  rem,
  input logic [ADDR_W-1:0] step,
  input logic [ADDR_W-1:0] addr_o,
  input logic              last_o,
  input logic              done_o
);

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (addr_o == '0 && !last_o && !done_o));

  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ack_i && !last_o) |=> (addr_o == ADDR_W'($past(addr_o) + $past(step))));

  p_quad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && quad_i) |=> (addr_o == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ack_i) |=> $stable(addr_o));

  p_wide_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step == ADDR_W'(4)) |-> (addr_o[1:0] == 2'b00));

  p_half_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step == ADDR_W'(2)) |-> (addr_o[0] == 1'b0));

  p_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> (active && rem == CNT_W'(1)));

  p_done_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (last_o && ack_i));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!last_o && addr_o == '0));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start_i && !ack_i) |=> ($stable(addr_o) && $stable(rem) && active));

endmodule

bind subword_addr_ctr swa_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .quad_i  (quad_i),
  .ack_i   (ack_i),
  .accept  (accept_w),
  .active  (active_w),
  .rem     (rem_w),
  .step    (step_w),
  .addr_o  (addr_o),
  .last_o  (last_o),
  .done_o  (done_o)
);

// File: tb/sim_subword_addr_ctr.sv
module sim_subword_addr_ctr;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] tgt_addr_i = '0;
  logic [1:0] dsize_i = '0;
  logic [1:0] pwidth_i = '0;
  logic       quad_i = 1'b0;
  logic       ack_i = 1'b0;
  logic [3:0] addr_o;
  logic       last_o;
  logic       done_o;

  int checks = 0;
  int failures = 0;
  bit armed = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0] addr;
    bit         last;
    string      req;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  subword_addr_ctr u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_addr_i(tgt_addr_i),
    .dsize_i(dsize_i), .pwidth_i(pwidth_i), .quad_i(quad_i), .ack_i(ack_i),
    .addr_o(addr_o), .last_o(last_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: compares the address lines against the scoreboard front
  always @(negedge clk) begin
    if (armed) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3", "extra datum", 1, 0);
      end else begin
        check(addr_o == sb[0].addr, ack_i ? sb[0].req : "R6", "addr",
              int'(addr_o), int'(sb[0].addr));
        check(last_o == sb[0].last, "R8", "last", int'(last_o), int'(sb[0].last));
        if (ack_i) begin
          check(done_o == sb[0].last, "R9", "done", int'(done_o), int'(sb[0].last));
          void'(sb.pop_front());
        end else begin
          check(done_o == 1'b0, "R9", "done idle", int'(done_o), 0);
        end
      end
    end
  end

  // Driver: builds the expected sequence, then runs the transfer
  task automatic run_xfer(input logic [3:0] tgt, input logic [1:0] ds,
                          input logic [1:0] pw, input bit q, input int gap,
                          input bit poke, input string req);
    int pb = (pw == 2'd0) ? 1 : (pw == 2'd1) ? 2 : 4;
    int db = (ds == 2'd0) ? 1 : (ds == 2'd1) ? 2 : 4;
    int n  = q ? 16 / pb : ((db > pb) ? db / pb : 1);
    int base = q ? 0 : (int'(tgt) - (int'(tgt) % pb));
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.addr = 4'((base + i * pb) % 16);
      e.last = (i == n - 1);
      e.req  = (i == 0) ? req : "R4";
      sb.push_back(e);
    end
    @(posedge clk); #1;
    start_i = 1'b1; tgt_addr_i = tgt; dsize_i = ds; pwidth_i = pw; quad_i = q;
    @(posedge clk); #1;
    start_i = 1'b0;
    armed = 1'b1;
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        if (poke) begin
          start_i = 1'b1; tgt_addr_i = ~tgt; quad_i = ~q; pwidth_i = 2'd0;
        end
        @(posedge clk); #1;
      end
      start_i = 1'b0;
      ack_i = 1'b1;
      @(posedge clk); #1;
      ack_i = 1'b0;
    end
    armed = 1'b0;
    check(sb.size() == 0, "R3", "data left", sb.size(), 0);
    sb.delete();
    @(negedge clk);
    check(addr_o == 4'd0, "R9", "idle addr", int'(addr_o), 0);
    check(last_o == 1'b0, "R1", "idle last", int'(last_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(addr_o == 4'd0, "R1", "reset addr", int'(addr_o), 0);
    check(last_o == 1'b0, "R1", "reset last", int'(last_o), 0);
    check(done_o == 1'b0, "R1", "reset done", int'(done_o), 0);
    // ack while idle has no effect (R1)
    @(posedge clk); #1 ack_i = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0, "R1", "idle ack done", int'(done_o), 0);
    @(posedge clk); #1 ack_i = 1'b0;
    @(negedge clk);
    check(addr_o == 4'd0, "R1", "idle ack addr", int'(addr_o), 0);

    run_xfer(4'h5, 2'd0, 2'd0, 1'b0, 1, 1'b0, "R2");  // byte on 8-bit
    run_xfer(4'h4, 2'd2, 2'd0, 1'b0, 0, 1'b0, "R3");  // word on 8-bit
    run_xfer(4'h6, 2'd1, 2'd1, 1'b0, 2, 1'b0, "R2");  // half on 16-bit
    run_xfer(4'h8, 2'd2, 2'd1, 1'b0, 1, 1'b0, "R3");  // word on 16-bit
    run_xfer(4'hE, 2'd2, 2'd2, 1'b0, 1, 1'b0, "R7");  // word on 32, low bits cleared
    run_xfer(4'hB, 2'd1, 2'd0, 1'b0, 0, 1'b0, "R3");  // half on 8-bit
    run_xfer(4'h7, 2'd0, 2'd3, 1'b0, 1, 1'b0, "R7");  // byte on 32 (code 3)
    run_xfer(4'h3, 2'd0, 2'd1, 1'b0, 1, 1'b0, "R7");  // byte on 16-bit
    run_xfer(4'h9, 2'd2, 2'd2, 1'b1, 1, 1'b0, "R5");  // quad 32-bit
    run_xfer(4'h9, 2'd2, 2'd1, 1'b1, 0, 1'b0, "R5");  // quad 16-bit
    run_xfer(4'h9, 2'd2, 2'd0, 1'b1, 1, 1'b0, "R5");  // quad 8-bit
    run_xfer(4'h6, 2'd0, 2'd2, 1'b1, 0, 1'b0, "R11"); // quad, byte size code
    run_xfer(4'h4, 2'd2, 2'd1, 1'b0, 2, 1'b1, "R10"); // start pokes during transfer
    run_xfer(4'h0, 2'd1, 2'd2, 1'b1, 2, 1'b1, "R10");

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule